// File: doc/BRIEF.md
# Weight Tile Staging Queue

This block sits between a read-only weight store and the weight loader of an N×N multiply array. A fetch command carries the base address of one weight tile. The command is accepted in the cycle its address request goes out to the memory, and the block does not wait for the data. Because the command retires early, the sequencer can go on issuing work while weights are still on their way.

The memory answers each request with N beats, in request order. Each beat is one tile row of N signed or unsigned 8-bit elements. The beats are collected into one of four tile slots. A slot is reserved when its fetch is issued and becomes complete after its N-th beat. The consumer receives complete tiles one row per cycle, in fetch order, over a valid/ready port. The consumer only waits when the next tile has not fully arrived.

Two status outputs report how many slots are reserved and how many are complete. A flush input empties the queue. The block has no write path towards the memory. Both N and the slot count must be powers of two, at least 2.

Top module: `wtile_stage_fifo`

## Requirements
- R1: A fetch is accepted (`fetch_ready` and `fetch_valid` both high) exactly when the memory request goes out in the same cycle, with `mem_req_addr` equal to `fetch_addr`. Acceptance does not depend on any response data. `reserved_count` rises by one on the next cycle.
- R2: At most SLOTS (default 4) tiles are reserved, counting in-flight and complete tiles. `fetch_ready` and `mem_req_valid` are low while all slots are reserved and no slot is released in that cycle.
- R3: A slot is released in the cycle its last row is accepted. A fetch offered in that same cycle is accepted even though the queue was full.
- R4: Response beats fill tiles in request order, one N-byte row per beat. A tile becomes complete, and `complete_count` rises by one, on the cycle after its N-th beat.
- R5: `tile_valid` is high exactly when at least one complete tile is held. Beats of a partly arrived tile never make it visible.
- R6: Tiles are delivered in fetch order. Rows come out in arrival order, one per accepted cycle. `tile_last` is high on row N-1.
- R7: While `tile_valid` is high and `tile_ready` is low, `tile_valid`, `tile_row` and `tile_last` hold their values into the next cycle.
- R8: `flush` clears both counts and `tile_valid` on the next cycle. Beats still owed for requests issued before the flush are discarded, and fetches are refused (`fetch_ready` low) until all of those beats have arrived. No fetch is accepted in a flush cycle.
- R9: After reset both counts are zero and `tile_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty the queue and drop owed beats |
| fetch_valid | input | 1 | Fetch command offered |
| fetch_addr | input | AW | Tile base address |
| fetch_ready | output | 1 | Fetch accepted and request issued |
| mem_req_valid | output | 1 | Read request to weight memory |
| mem_req_addr | output | AW | Read request address |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | One response beat present |
| mem_rsp_data | input | N*8 | One tile row |
| tile_valid | output | 1 | A complete tile row is offered |
| tile_row | output | N*8 | Row to the matrix loader |
| tile_last | output | 1 | Offered row is row N-1 |
| tile_ready | input | 1 | Loader accepts the row |
| reserved_count | output | clog2(SLOTS+1) | Reserved slots |
| complete_count | output | clog2(SLOTS+1) | Complete slots |

## Verification
The bench builds the block with N=4, four slots and a 16-bit address. With these values a tile is only four beats long, so full-queue back-pressure, same-cycle re-reservation and flushes with beats still owed all occur many times within a few thousand cycles. A behavioural model made of address queues and epoch tags predicts the counts, the offered row and the fetch handshake on every cycle. The bench runs phases that starve the consumer, starve the memory, flush at random, and stream at full rate.

// File: rtl/wtile_stage_fifo.sv
module wtile_stage_fifo #(
  parameter int N = 8,
  parameter int SLOTS = 4,
  parameter int AW = 32,
  localparam int CW = $clog2(SLOTS + 1),
  localparam int RW = N * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_ready,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [RW-1:0] mem_rsp_data,
  output logic          tile_valid,
  output logic [RW-1:0] tile_row,
  output logic          tile_last,
  input  logic          tile_ready,
  output logic [CW-1:0] reserved_count,
  output logic [CW-1:0] complete_count
);
  localparam int SW = $clog2(SLOTS);
  localparam int ROWW = $clog2(N);
  localparam int DW = $clog2(SLOTS * N + 1);

  logic [RW-1:0]   store [SLOTS*N];
  logic [SW-1:0]   fill_slot, rd_slot;
  logic [ROWW-1:0] fill_row, rd_row;
  logic [CW-1:0]   res_q, done_q;
  logic [DW-1:0]   drop_q, owed;
  logic            pop, release_now, slot_open, issue, beat_wr, tile_done;

  assign tile_valid     = done_q != '0;
  assign tile_row       = store[{rd_slot, rd_row}];
  assign tile_last      = rd_row == ROWW'(N - 1);
  assign pop            = tile_valid && tile_ready;
  assign release_now    = pop && tile_last;
  assign slot_open      = (res_q < CW'(SLOTS)) || release_now;
  assign mem_req_valid  = fetch_valid && slot_open && !flush && drop_q == '0;
  assign mem_req_addr   = fetch_addr;
  assign fetch_ready    = slot_open && mem_req_ready && !flush && drop_q == '0;
  assign issue          = fetch_valid && fetch_ready;
  assign beat_wr        = mem_rsp_valid && drop_q == '0;
  assign tile_done      = beat_wr && fill_row == ROWW'(N - 1);
  assign owed           = (DW'(res_q - done_q) << ROWW) - DW'(fill_row);
  assign reserved_count = res_q;
  assign complete_count = done_q;

  always_ff @(posedge clk)
    if (beat_wr && !flush) store[{fill_slot, fill_row}] <= mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0; done_q <= '0; drop_q <= '0;
      fill_slot <= '0; fill_row <= '0; rd_slot <= '0; rd_row <= '0;
    end else if (flush) begin
      res_q <= '0; done_q <= '0;
      fill_slot <= '0; fill_row <= '0; rd_slot <= '0; rd_row <= '0;
      drop_q <= drop_q + owed - DW'(mem_rsp_valid);
    end else begin
      res_q  <= res_q + CW'(issue) - CW'(release_now);
      done_q <= done_q + CW'(tile_done) - CW'(release_now);
      if (mem_rsp_valid && drop_q != '0) drop_q <= drop_q - 1'b1;
      if (beat_wr) fill_row <= fill_row + 1'b1;
      if (tile_done) fill_slot <= fill_slot + 1'b1;
      if (pop) rd_row <= rd_row + 1'b1;
      if (release_now) rd_slot <= rd_slot + 1'b1;
    end
  end

  assert_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_count <= CW'(SLOTS));
  assert_full_bp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reserved_count == CW'(SLOTS) && !(tile_valid && tile_ready && tile_last)) |-> !fetch_ready);
  assert_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> reserved_count != '0);
  assert_done_le_res_R4: assert property (@(posedge clk) disable iff (!rst_n)
    complete_count <= reserved_count);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_valid && !tile_ready && !flush) |=> (tile_valid && $stable(tile_row) && $stable(tile_last)));
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (reserved_count == '0 && !tile_valid));
endmodule

// File: tb/wtile_stage_fifo_tb_top.sv
module wtile_stage_fifo_tb_top;
  localparam int N = 4, SLOTS = 4, AW = 16, RW = N * 8, CW = $clog2(SLOTS + 1);

  logic clk = 0, rst_n = 0, flush = 0;
  logic fetch_valid = 0, fetch_ready, mem_req_valid, mem_req_ready = 0;
  logic [AW-1:0] fetch_addr = '0, mem_req_addr;
  logic mem_rsp_valid = 0, tile_valid, tile_last, tile_ready = 0;
  logic [RW-1:0] mem_rsp_data = '0, tile_row;
  logic [CW-1:0] reserved_count, complete_count;

  wtile_stage_fifo #(.N(N), .SLOTS(SLOTS), .AW(AW)) dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [AW-1:0] ref_q[$], mem_addr[$];
  int mem_ep[$];
  int done = 0, rows_got = 0, rd_row = 0, mem_beat = 0, epoch = 0;
  int hit_bp = 0, hit_rr = 0, hit_fl = 0, hit_stall = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] pat(input logic [AW-1:0] a, input int r);
    logic [RW-1:0] v;
    for (int b = 0; b < N; b++) v[b*8 +: 8] = a[7:0] ^ 8'(r * 16 + b * 5 + int'(a[15:8]));
    return v;
  endfunction

  function automatic bit chance(input int pct);
    return $urandom_range(99) < pct;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit slot_ok, stale, exp_rdy, pop, iss;
    int pf, pr, pt, pfl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reserved_count == 0, "R9", "reserved_count after reset", 64'(reserved_count), 0);
    chk(complete_count == 0, "R9", "complete_count after reset", 64'(complete_count), 0);
    chk(tile_valid == 0, "R9", "tile_valid after reset", 64'(tile_valid), 0);
    rst_n = 1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      // registered outputs against model state
      chk(reserved_count == CW'(ref_q.size()), "R1 R2", "reserved_count", 64'(reserved_count), 64'(ref_q.size()));
      chk(complete_count == CW'(done), "R4", "complete_count", 64'(complete_count), 64'(done));
      chk(tile_valid == (done > 0), "R5", "tile_valid", 64'(tile_valid), 64'(done > 0));
      if (done == 0 && rows_got > 0) hit_stall++;
      if (done > 0) begin
        chk(tile_row == pat(ref_q[0], rd_row), "R6 R7", "tile_row", 64'(tile_row), 64'(pat(ref_q[0], rd_row)));
        chk(tile_last == (rd_row == N - 1), "R6", "tile_last", 64'(tile_last), 64'(rd_row == N - 1));
      end
      case (cyc / 750)
        0: begin pf = 70; pr = 30; pt = 10; pfl = 0; end
        1: begin pf = 50; pr = 60; pt = 60; pfl = 0; end
        2: begin pf = 60; pr = 50; pt = 50; pfl = 3; end
        default: begin pf = 90; pr = 100; pt = 100; pfl = 0; end
      endcase
      flush = chance(pfl);
      fetch_valid = chance(pf);
      fetch_addr = AW'($urandom);
      mem_req_ready = chance(80);
      mem_rsp_valid = mem_addr.size() > 0 && chance(pr);
      mem_rsp_data = mem_addr.size() > 0 ? pat(mem_addr[0], mem_beat) : '0;
      tile_ready = chance(pt);
      #1;
      pop = done > 0 && tile_ready && !flush;
      slot_ok = ref_q.size() < SLOTS || (done > 0 && tile_ready && rd_row == N - 1);
      stale = 0;
      foreach (mem_ep[i]) if (mem_ep[i] != epoch) stale = 1;
      exp_rdy = slot_ok && mem_req_ready && !flush && !stale;
      chk(fetch_ready == exp_rdy, "R1 R2 R3 R8", "fetch_ready", 64'(fetch_ready), 64'(exp_rdy));
      chk(mem_req_valid == (fetch_valid && slot_ok && !flush && !stale), "R1 R2",
          "mem_req_valid", 64'(mem_req_valid), 64'(fetch_valid && slot_ok && !flush && !stale));
      if (mem_req_valid) chk(mem_req_addr == fetch_addr, "R1", "mem_req_addr", 64'(mem_req_addr), 64'(fetch_addr));
      iss = fetch_valid && exp_rdy;
      if (fetch_valid && ref_q.size() == SLOTS && !slot_ok) hit_bp++;
      if (iss && ref_q.size() == SLOTS) hit_rr++;
      if (flush && mem_addr.size() > 0) hit_fl++;
      if (mem_rsp_valid) begin
        if (mem_ep[0] == epoch && !flush) begin
          rows_got++;
          if (rows_got == N) begin done++; rows_got = 0; end
        end
        mem_beat++;
        if (mem_beat == N) begin void'(mem_addr.pop_front()); void'(mem_ep.pop_front()); mem_beat = 0; end
      end
      if (pop) begin
        rd_row++;
        if (rd_row == N) begin void'(ref_q.pop_front()); done--; rd_row = 0; end
      end
      if (iss) begin
        ref_q.push_back(fetch_addr);
        mem_addr.push_back(fetch_addr);
        mem_ep.push_back(epoch);
      end
      if (flush) begin
        ref_q.delete(); done = 0; rows_got = 0; rd_row = 0; epoch++;
      end
    end
    chk(hit_bp > 0, "R2", "full-queue back-pressure seen", 64'(hit_bp), 1);
    chk(hit_rr > 0, "R3", "same-cycle re-reserve seen", 64'(hit_rr), 1);
    chk(hit_fl > 0, "R8", "flush with owed beats seen", 64'(hit_fl), 1);
    chk(hit_stall > 0, "R5", "partial tile held back seen", 64'(hit_stall), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule